// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sequences the low-power states of a small microcontroller core. Software first writes a control register that holds a sleep-enable bit and a two-bit mode field. The CPU then pulses a one-cycle sleep strobe. If sleep is enabled at that moment, the controller halts the CPU and drops clock enables according to the selected mode.

While asleep, the block waits for an enabled interrupt. It then optionally counts an oscillator start-up period, holds the CPU halted for a further four cycles, and hands control back. A chip reset request that arrives during sleep ends sleep at once and is reported as a reset wake. The block drives only enables and a halt line. It never clears or resets any storage, so the register file and SRAM are untouched across sleep.

Top module: `sleep_power_ctl`

## Requirements
- R1: After reset, `pm_state` is 0 (running), all four clock enables are 1, `cpu_halt` is 0, `wake_by_reset` is 0, and `reg_rdata` is 0x00.
- R2: A register write stores data bit 5 as sleep-enable and data bits 6 and 4 as the mode field (bit 6 is the high mode bit). `reg_rdata` returns those three bits in the same positions, and every other bit reads 0.
- R3: While running, a sleep strobe with sleep-enable at 0 is ignored: `pm_state` stays 0 and `cpu_halt` stays 0.
- R4: While running, a sleep strobe with sleep-enable at 1 sets `pm_state` to 1 (asleep) and `cpu_halt` to 1 after the next clock edge. The state codes are 0 running, 1 asleep, 2 start-up, 3 post-wake hold.
- R5: Mode 00 (Idle): while asleep, the CPU and flash enables are 0 and the I/O and async/timer enables are 1.
- R6: Modes 01 and 10 both select Power-down. All four enables are 0 while asleep and during start-up.
- R7: Mode 11 (Standby): all four enables are 0 while asleep. On wake, start-up lasts STANDBY_CYCLES cycles and does not wait for the oscillator-ready input.
- R8: An interrupt wake from Idle goes straight to the hold state. `cpu_halt` stays 1 for exactly 4 cycles counted from the wake edge, and then the state returns to running.
- R9: An interrupt wake from Power-down spends STARTUP_CYCLES cycles in start-up, then 4 cycles in hold. Start-up is extended for as long as `osc_ready` is 0.
- R10: In the hold state, all four clock enables are 1 and `cpu_halt` is 1.
- R11: `core_rst` while not running returns the state to running on the next edge and sets `wake_by_reset` to 1. It also clears the control register. An interrupt wake sets `wake_by_reset` to 0.
- R12: Sleep-enable is not cleared by a wake, so a second strobe after an interrupt wake enters sleep again.
- R13: A sleep strobe arriving while not running is ignored, and `irq_pend` has no effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| core_rst | input | 1 | Synchronous chip reset request |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_stb | input | 1 | One-cycle sleep instruction strobe |
| irq_pend | input | 1 | An enabled interrupt is pending |
| osc_ready | input | 1 | Oscillator has stabilised |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_async | output | 1 | Async/timer clock enable |
| cpu_halt | output | 1 | CPU held halted |
| pm_state | output | 2 | Current controller state |
| wake_by_reset | output | 1 | 1 if the last wake was caused by reset |

## Verification
Every result comes from one register stage. State, halt and enables therefore change one edge after the strobe, interrupt or reset that causes them. The wake latency is counted from that edge: 4 cycles for Idle, STARTUP_CYCLES+4 for Power-down and STANDBY_CYCLES+4 for Standby. The bench drives inputs on the falling edge and samples outputs one nanosecond after the rising edge or at the falling edge. It counts the latency by stepping one rising edge at a time until the state reads 0.

// File: rtl/sleep_power_ctl.sv
module sleep_power_ctl #(
  parameter int STARTUP_CYCLES = 16,
  parameter int STANDBY_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_rst,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sleep_stb,
  input  logic       irq_pend,
  input  logic       osc_ready,
  output logic       clk_en_cpu,
  output logic       clk_en_flash,
  output logic       clk_en_io,
  output logic       clk_en_async,
  output logic       cpu_halt,
  output logic [1:0] pm_state,
  output logic       wake_by_reset
);

  localparam int HOLD_CYCLES = 4;
  localparam int MAXC = (STARTUP_CYCLES > HOLD_CYCLES) ?
                        ((STARTUP_CYCLES > STANDBY_CYCLES) ? STARTUP_CYCLES : STANDBY_CYCLES) :
                        ((HOLD_CYCLES > STANDBY_CYCLES) ? HOLD_CYCLES : STANDBY_CYCLES);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_DOZE = 2'd1, ST_WARM = 2'd2, ST_HOLD = 2'd3} pm_t;

  pm_t           st;
  logic          se_q;
  logic [1:0]    sel_q;
  logic [1:0]    mode_q;
  logic [CW-1:0] cnt;
  logic          rst_wake_q;
  logic [CW-1:0] warm_lim;

  wire is_idle = (mode_q == 2'b00);
  wire is_stby = (mode_q == 2'b11);

  assign warm_lim = is_stby ? CW'(STANDBY_CYCLES) : CW'(STARTUP_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RUN;
      se_q       <= 1'b0;
      sel_q      <= 2'b00;
      mode_q     <= 2'b00;
      cnt        <= '0;
      rst_wake_q <= 1'b0;
    end else if (core_rst) begin
      st         <= ST_RUN;
      se_q       <= 1'b0;
      sel_q      <= 2'b00;
      cnt        <= '0;
      rst_wake_q <= (st != ST_RUN);
    end else begin
      if (reg_we) begin
        sel_q <= {reg_wdata[6], reg_wdata[4]};
        se_q  <= reg_wdata[5];
      end
      case (st)
        ST_RUN: begin
          if (sleep_stb && se_q) begin
            st     <= ST_DOZE;
            mode_q <= sel_q;
          end
        end
        ST_DOZE: begin
          if (irq_pend) begin
            rst_wake_q <= 1'b0;
            cnt        <= '0;
            st         <= (is_idle || warm_lim == '0) ? ST_HOLD : ST_WARM;
          end
        end
        ST_WARM: begin
          if (cnt == warm_lim - 1'b1) begin
            if (osc_ready || is_stby) begin
              st  <= ST_HOLD;
              cnt <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(HOLD_CYCLES - 1)) begin
            st  <= ST_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  wire run   = (st == ST_RUN);
  wire awake = run || (st == ST_HOLD);
  wire light = (st == ST_DOZE) && is_idle;

  assign clk_en_cpu    = awake;
  assign clk_en_flash  = awake;
  assign clk_en_io     = awake || light;
  assign clk_en_async  = awake || light;
  assign cpu_halt      = !run;
  assign pm_state      = st;
  assign wake_by_reset = rst_wake_q;
  assign reg_rdata     = {1'b0, sel_q[1], se_q, sel_q[0], 4'b0000};

  AST_SLEEP_NEEDS_SE: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_stb && !reg_rdata[5] && !core_rst) |=> (pm_state == 2'd0)); // R3
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && sleep_stb && reg_rdata[5] && !core_rst) |=> (pm_state == 2'd1 && cpu_halt)); // R4
  AST_IDLE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd1 && mode_q == 2'b00) |-> (!clk_en_cpu && !clk_en_flash && clk_en_io && clk_en_async)); // R5
  AST_DEEP_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state != 2'd0 && pm_state != 2'd3 && mode_q != 2'b00) |-> !(clk_en_cpu || clk_en_flash || clk_en_io || clk_en_async)); // R6
  AST_HOLD_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd3) |-> (clk_en_cpu && clk_en_flash && clk_en_io && clk_en_async && cpu_halt)); // R10
  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd0 && $past(pm_state) == 2'd3 && !$past(core_rst)) |-> ($past(pm_state, 4) == 2'd3)); // R8
  AST_WARM_WAITS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd2 && !osc_ready && mode_q != 2'b11 && !core_rst) |=> (pm_state == 2'd2)); // R9
  AST_RESET_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst && pm_state != 2'd0) |=> (pm_state == 2'd0 && wake_by_reset && !cpu_halt)); // R11
  AST_STROBE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 2'd1 && !irq_pend && !core_rst) |=> (pm_state == 2'd1)); // R13

endmodule

// File: tb/sleep_power_ctl_tb.sv
`timescale 1ns/1ps
module sleep_power_ctl_tb_top;
  localparam int PD = 16;
  localparam int SB = 2;

  logic clk = 1'b0, rst_n = 1'b0, core_rst = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic sleep_stb = 1'b0, irq_pend = 1'b0, osc_ready = 1'b1;
  logic clk_en_cpu, clk_en_flash, clk_en_io, clk_en_async, cpu_halt, wake_by_reset;
  logic [1:0] pm_state;
  int applied = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_power_ctl #(.STARTUP_CYCLES(PD), .STANDBY_CYCLES(SB)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_stb(sleep_stb), .irq_pend(irq_pend), .osc_ready(osc_ready),
    .clk_en_cpu(clk_en_cpu), .clk_en_flash(clk_en_flash), .clk_en_io(clk_en_io),
    .clk_en_async(clk_en_async), .cpu_halt(cpu_halt), .pm_state(pm_state),
    .wake_by_reset(wake_by_reset));

  // {mode[11:10], enables cpu/flash/io/async while asleep [9:6], wake latency [5:0]}
  localparam logic [11:0] VEC [4] = '{
    {2'b00, 4'b0011, 6'd4},
    {2'b01, 4'b0000, 6'(PD + 4)},
    {2'b10, 4'b0000, 6'(PD + 4)},
    {2'b11, 4'b0000, 6'(SB + 4)}
  };

  task automatic chk(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ens();
    return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_async};
  endfunction

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); sleep_stb = 1'b1;
    @(negedge clk); sleep_stb = 1'b0;
  endtask

  task automatic wake_count(output int n);
    @(negedge clk); irq_pend = 1'b1;
    @(posedge clk); #1; irq_pend = 1'b0;
    n = 0;
    while (pm_state != 2'd0 && n < 500) begin
      n++;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", pm_state, 0);
    chk("R1 enables", ens(), 15);
    chk("R1 halt", cpu_halt, 0);
    chk("R1 flag", wake_by_reset, 0);
    chk("R1 rdata", reg_rdata, 0);

    write_reg(8'hFF);
    chk("R2 readback", reg_rdata, 8'h70);
    write_reg(8'h50);
    chk("R2 mode only", reg_rdata, 8'h50);
    strobe();
    chk("R3 ignored state", pm_state, 0);
    chk("R3 ignored halt", cpu_halt, 0);

    for (int i = 0; i < 4; i++) begin
      logic [1:0] m;
      m = VEC[i][11:10];
      write_reg({1'b0, m[1], 1'b1, m[0], 4'b0});
      strobe();
      chk("R4 asleep", pm_state, 1);
      chk("R4 halt", cpu_halt, 1);
      chk("R5/R6/R7 sleep enables", ens(), int'(VEC[i][9:6]));
      wake_count(n);
      chk("R8/R9/R7 wake latency", n, int'(VEC[i][5:0]));
      chk("R11 irq flag", wake_by_reset, 0);
      chk("R12 se kept", reg_rdata[5], 1);
    end

    // R10 hold enables and R13 strobe during hold
    write_reg(8'h20);
    strobe();
    @(negedge clk); irq_pend = 1'b1;
    @(posedge clk); #1; irq_pend = 1'b0;
    chk("R10 hold state", pm_state, 3);
    chk("R10 hold enables", ens(), 15);
    chk("R10 hold halt", cpu_halt, 1);
    @(negedge clk); sleep_stb = 1'b1;
    @(negedge clk); sleep_stb = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 strobe in hold ignored", pm_state, 0);
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
    chk("R13 irq while running", pm_state, 0);
    chk("R13 irq halt", cpu_halt, 0);

    // R12 re-entry
    strobe();
    chk("R12 re-enter", pm_state, 1);
    wake_count(n);
    chk("R8 idle latency again", n, 4);

    // R9 oscillator not ready extends start-up
    write_reg(8'h30);
    osc_ready = 1'b0;
    strobe();
    @(negedge clk); irq_pend = 1'b1;
    @(negedge clk); irq_pend = 1'b0;
    repeat (PD + 10) @(negedge clk);
    chk("R9 waiting osc", pm_state, 2);
    chk("R6 startup enables", ens(), 0);
    osc_ready = 1'b1;
    @(posedge clk); #1;
    n = 0;
    while (pm_state != 2'd0 && n < 500) begin
      n++;
      @(posedge clk); #1;
    end
    chk("R9 hold after osc", n, 4);

    // R11 reset during sleep
    write_reg(8'h70);
    strobe();
    chk("R11 asleep", pm_state, 1);
    @(negedge clk); core_rst = 1'b1;
    @(negedge clk); core_rst = 1'b0;
    chk("R11 state", pm_state, 0);
    chk("R11 flag", wake_by_reset, 1);
    chk("R11 halt", cpu_halt, 0);
    chk("R11 reg cleared", reg_rdata, 0);
    strobe();
    chk("R3 cleared se", pm_state, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule